// File: doc/BRIEF.md
# Multiplexed Burst Bus Master Controller

This block is the master side of a 32-bit local bus on which address and data share the same lines. An internal agent hands it one request at a time. Each request carries a word address, an operation (read, write, read-modify-write or interrupt acknowledge), a burst length of one to four words and the write data for every word of the burst. The controller then runs the bus protocol. It puts out one address state, then one data state per word, and stretches a data state with wait states for as long as the target holds off READY.

In the address state the two low bus bits carry the burst length, so a target knows how many words follow. Read data comes back on a per-word valid strobe one cycle after the target accepts each word. For a read-modify-write, the controller first waits until no other agent holds the shared LOCK line. It then asserts LOCK for the read burst, goes through a single idle cycle and runs a write burst to the same words, releasing LOCK in the address state of that write. An interrupt acknowledge is a read that holds LOCK for its whole length.

Three-state and open-drain pins are modelled as a drive value plus an enable. A request whose length is zero, above four, or runs past a 16-byte line is refused with a one-cycle error pulse, and no bus activity follows.

Top module: `lbus_master`

## Requirements
- R1: In the address state the bus drives {word address, length-1} (bits 31..2 the word address, bits 1..0 the count minus one), with bus_ad_oe_o high, ale_no and ads_no low and den_no high.
- R2: In each data state of a write, word k of the burst (bits 32k+31..32k of req_wdata_i) is driven with bus_ad_oe_o high. For a read, bus_ad_oe_o is low, and rdata_o/rvalid_o present the bus value one cycle after each clock edge on which ready_i is high in a data state.
- R3: ale_no is low only in the address state and is high again in the first data state.
- R4: ads_no is high in the first data state and in every wait state. It is low in a data state that directly follows a cycle in which a non-final word was accepted.
- R5: req_op_i codes are 0 read, 1 write, 2 read-modify-write, 3 interrupt acknowledge. wr_o and dtr_o are 1 for a write and 0 for a read or an interrupt acknowledge. Both are valid from the address state and do not change while den_no is low.
- R6: den_no is low in every data and wait state and high in the address and idle states.
- R7: When ready_i is low in a data state, the same word is repeated in the next cycle (a wait state), with the same write data.
- R8: A read-modify-write first waits while lock_i is high at acceptance, with no address state. It then holds lock_oe_o from the read address state through the idle gap, performs a write to the same words, and drops lock_oe_o in that write's address state.
- R9: An interrupt acknowledge asserts lock_oe_o in its address and data states and runs as a read.
- R10: After the final word is accepted, the next cycle is idle with the bus released (bus_ad_oe_o low). req_ready_o is low during any transaction and high again in that idle cycle, except in the gap between the two halves of a read-modify-write.
- R11: A request with length 0, length above 4, or (address bits 1..0 + length) above 4 is refused. err_o is high for exactly the one cycle after acceptance, and no address state follows.
- R12: Asynchronous reset (rst_ni low) immediately returns the controller to idle: all strobes high, bus released, lock_oe_o low, rvalid_o and err_o low, req_ready_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted on this edge when valid |
| req_op_i | input | 2 | Operation code |
| req_addr_i | input | 30 | Word address |
| req_len_i | input | 3 | Burst length in words |
| req_wdata_i | input | 128 | Write data, word k in bits 32k+31..32k |
| err_o | output | 1 | Request refused pulse |
| rdata_o | output | 32 | Read data word |
| rvalid_o | output | 1 | Read data word valid |
| bus_ad_i | input | 32 | Address/data lines as seen on the bus |
| bus_ad_o | output | 32 | Address/data drive value |
| bus_ad_oe_o | output | 1 | Address/data drive enable |
| ale_no | output | 1 | Address latch strobe, active low |
| ads_no | output | 1 | Address/data status strobe, active low |
| wr_o | output | 1 | Write (1) or read (0) |
| dtr_o | output | 1 | Transceiver direction, 1 = transmit |
| den_no | output | 1 | Data transceiver enable, active low |
| ready_i | input | 1 | Target accepts or presents the current word |
| lock_i | input | 1 | Shared lock line seen asserted |
| lock_oe_o | output | 1 | Controller pulls the lock line to asserted |

## Verification
The properties assume that ready_i is meaningful only in data states, that lock_i is the shared line as seen on the bus, and that request fields hold steady while req_valid_i is high. The stimulus only presents requests while waiting for req_ready_o and keeps every field constant until acceptance. It raises ready_i only in cycles where den_no is low, following a fixed wait count per word. It holds lock_i high only in the lock-contention case, and releases it before the controller could drive the line itself.

// File: rtl/lbus_pkg.sv
package lbus_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_INTA  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOCKWAIT,
    ST_ADDR,
    ST_DATA
  } state_e;
endpackage

// File: rtl/lbus_req_check.sv
module lbus_req_check #(
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 3,
  parameter int OFF_W     = 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             bad_o
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] end_w;

  always_comb begin
    end_w = SUM_W'(off_i) + SUM_W'(len_i);
    bad_o = (len_i == '0)
         || (SUM_W'(len_i) > SUM_W'(MAX_BEATS))
         || (end_w > SUM_W'(MAX_BEATS));
  end
endmodule

// File: rtl/lbus_seq.sv
module lbus_seq
  import lbus_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 3,
  parameter int BEAT_W    = 2,
  parameter int WA_W      = 30
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [1:0]              req_op_i,
  input  logic [WA_W-1:0]         req_addr_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic [MAX_BEATS*DW-1:0] req_wdata_i,
  input  logic                    req_bad_i,
  input  logic                    ready_i,
  input  logic                    lock_i,
  input  logic [DW-1:0]           bus_ad_i,
  output logic                    req_ready_o,
  output state_e                  state_o,
  output logic [WA_W-1:0]         addr_o,
  output logic [LEN_W-1:0]        len_o,
  output logic [BEAT_W-1:0]       beat_o,
  output logic [MAX_BEATS*DW-1:0] wdata_o,
  output logic                    acc_o,
  output logic                    wr_o,
  output logic                    dtr_o,
  output logic                    lock_oe_o,
  output logic [DW-1:0]           rdata_o,
  output logic                    rvalid_o,
  output logic                    err_o
);
  state_e                  state_q;
  op_e                     op_q;
  logic [WA_W-1:0]         addr_q;
  logic [LEN_W-1:0]        len_q;
  logic [BEAT_W-1:0]       beat_q;
  logic [MAX_BEATS*DW-1:0] wdata_q;
  logic                    acc_q;      // previous cycle accepted a word
  logic                    rmw_wr_q;   // second half of a read-modify-write
  logic                    rmw_pend_q; // idle gap before that second half
  logic                    wr_q, dtr_q;
  logic [DW-1:0]           rdata_q;
  logic                    rvalid_q, err_q;

  logic start, last_beat, on_bus;
  op_e  req_op;

  always_comb begin
    req_op      = op_e'(req_op_i);
    req_ready_o = (state_q == ST_IDLE) && !rmw_pend_q;
    start       = req_valid_i && req_ready_o;
    last_beat   = LEN_W'(beat_q) == (len_q - LEN_W'(1));
    on_bus      = (state_q == ST_ADDR) || (state_q == ST_DATA);
    lock_oe_o   = ((op_q == OP_INTA) && on_bus)
               || ((op_q == OP_RMW) && ((on_bus && !rmw_wr_q) || rmw_pend_q));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      op_q       <= OP_READ;
      addr_q     <= '0;
      len_q      <= '0;
      beat_q     <= '0;
      wdata_q    <= '0;
      acc_q      <= 1'b0;
      rmw_wr_q   <= 1'b0;
      rmw_pend_q <= 1'b0;
      wr_q       <= 1'b0;
      dtr_q      <= 1'b0;
      rdata_q    <= '0;
      rvalid_q   <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rmw_pend_q) begin
            state_q    <= ST_ADDR;
            rmw_pend_q <= 1'b0;
            beat_q     <= '0;
            acc_q      <= 1'b0;
            wr_q       <= 1'b1;
            dtr_q      <= 1'b1;
          end else if (start) begin
            if (req_bad_i) begin
              err_q <= 1'b1;
            end else begin
              op_q     <= req_op;
              addr_q   <= req_addr_i;
              len_q    <= req_len_i;
              wdata_q  <= req_wdata_i;
              beat_q   <= '0;
              acc_q    <= 1'b0;
              rmw_wr_q <= 1'b0;
              wr_q     <= (req_op == OP_WRITE);
              dtr_q    <= (req_op == OP_WRITE);
              state_q  <= ((req_op == OP_RMW) && lock_i) ? ST_LOCKWAIT : ST_ADDR;
            end
          end
        end
        ST_LOCKWAIT: begin
          if (!lock_i) state_q <= ST_ADDR;
        end
        ST_ADDR: begin
          state_q <= ST_DATA;
        end
        ST_DATA: begin
          if (ready_i) begin
            acc_q <= 1'b1;
            if (!wr_q) begin
              rdata_q  <= bus_ad_i;
              rvalid_q <= 1'b1;
            end
            if (last_beat) begin
              state_q <= ST_IDLE;
              beat_q  <= '0;
              if ((op_q == OP_RMW) && !rmw_wr_q) begin
                rmw_pend_q <= 1'b1;
                rmw_wr_q   <= 1'b1;
              end
            end else begin
              beat_q <= beat_q + BEAT_W'(1);
            end
          end else begin
            acc_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = state_q;
  assign addr_o   = addr_q;
  assign len_o    = len_q;
  assign beat_o   = beat_q;
  assign wdata_o  = wdata_q;
  assign acc_o    = acc_q;
  assign wr_o     = wr_q;
  assign dtr_o    = dtr_q;
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign err_o    = err_q;
endmodule

// File: rtl/lbus_pin_drv.sv
module lbus_pin_drv
  import lbus_pkg::*;
#(
  parameter int DW        = 32,
  parameter int MAX_BEATS = 4,
  parameter int LEN_W     = 3,
  parameter int BEAT_W    = 2,
  parameter int WA_W      = 30
) (
  input  state_e                  state_i,
  input  logic [WA_W-1:0]         addr_i,
  input  logic [LEN_W-1:0]        len_i,
  input  logic [BEAT_W-1:0]       beat_i,
  input  logic [MAX_BEATS*DW-1:0] wdata_i,
  input  logic                    acc_i,
  input  logic                    wr_i,
  output logic [DW-1:0]           bus_ad_o,
  output logic                    bus_ad_oe_o,
  output logic                    ale_no,
  output logic                    ads_no,
  output logic                    den_no
);
  localparam int SIZE_W = DW - WA_W;

  logic [DW-1:0]     words [MAX_BEATS];
  logic [SIZE_W-1:0] size;

  for (genvar g = 0; g < MAX_BEATS; g++) begin : g_word
    assign words[g] = wdata_i[g*DW +: DW];
  end

  always_comb begin
    size        = SIZE_W'(len_i - LEN_W'(1));
    bus_ad_o    = '0;
    bus_ad_oe_o = 1'b0;
    ale_no      = 1'b1;
    ads_no      = 1'b1;
    den_no      = 1'b1;
    unique case (state_i)
      ST_ADDR: begin
        bus_ad_o    = {addr_i, size};
        bus_ad_oe_o = 1'b1;
        ale_no      = 1'b0;
        ads_no      = 1'b0;
      end
      ST_DATA: begin
        den_no      = 1'b0;
        ads_no      = !acc_i;  // re-strobe only after an accepted word
        bus_ad_oe_o = wr_i;
        bus_ad_o    = wr_i ? words[beat_i] : '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lbus_master.sv
module lbus_master
  import lbus_pkg::*;
#(
  parameter  int DW        = 32,
  parameter  int MAX_BEATS = 4,
  localparam int SIZE_W    = $clog2(MAX_BEATS),
  localparam int LEN_W     = $clog2(MAX_BEATS + 1),
  localparam int WA_W      = DW - SIZE_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic [1:0]              req_op_i,
  input  logic [WA_W-1:0]         req_addr_i,
  input  logic [LEN_W-1:0]        req_len_i,
  input  logic [MAX_BEATS*DW-1:0] req_wdata_i,
  output logic                    err_o,
  output logic [DW-1:0]           rdata_o,
  output logic                    rvalid_o,
  input  logic [DW-1:0]           bus_ad_i,
  output logic [DW-1:0]           bus_ad_o,
  output logic                    bus_ad_oe_o,
  output logic                    ale_no,
  output logic                    ads_no,
  output logic                    wr_o,
  output logic                    dtr_o,
  output logic                    den_no,
  input  logic                    ready_i,
  input  logic                    lock_i,
  output logic                    lock_oe_o
);
  state_e                  state;
  logic [WA_W-1:0]         addr;
  logic [LEN_W-1:0]        len;
  logic [SIZE_W-1:0]       beat;
  logic [MAX_BEATS*DW-1:0] wdata;
  logic                    acc, req_bad;

  lbus_req_check #(
    .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W), .OFF_W(SIZE_W)
  ) u_req_check (
    .off_i (req_addr_i[SIZE_W-1:0]),
    .len_i (req_len_i),
    .bad_o (req_bad)
  );

  lbus_seq #(
    .DW(DW), .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W), .BEAT_W(SIZE_W), .WA_W(WA_W)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (req_op_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .req_wdata_i (req_wdata_i),
    .req_bad_i   (req_bad),
    .ready_i     (ready_i),
    .lock_i      (lock_i),
    .bus_ad_i    (bus_ad_i),
    .req_ready_o (req_ready_o),
    .state_o     (state),
    .addr_o      (addr),
    .len_o       (len),
    .beat_o      (beat),
    .wdata_o     (wdata),
    .acc_o       (acc),
    .wr_o        (wr_o),
    .dtr_o       (dtr_o),
    .lock_oe_o   (lock_oe_o),
    .rdata_o     (rdata_o),
    .rvalid_o    (rvalid_o),
    .err_o       (err_o)
  );

  lbus_pin_drv #(
    .DW(DW), .MAX_BEATS(MAX_BEATS), .LEN_W(LEN_W), .BEAT_W(SIZE_W), .WA_W(WA_W)
  ) u_pin_drv (
    .state_i     (state),
    .addr_i      (addr),
    .len_i       (len),
    .beat_i      (beat),
    .wdata_i     (wdata),
    .acc_i       (acc),
    .wr_i        (wr_o),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe_o (bus_ad_oe_o),
    .ale_no      (ale_no),
    .ads_no      (ads_no),
    .den_no      (den_no)
  );
endmodule

// File: rtl/lbus_master_chk.sv
module lbus_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic err_o,
  input logic rvalid_o,
  input logic bus_ad_oe_o,
  input logic ale_no,
  input logic ads_no,
  input logic wr_o,
  input logic dtr_o,
  input logic den_no,
  input logic ready_i,
  input logic lock_oe_o
);
  // R1
  addr_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_no |-> (!ads_no && den_no && bus_ad_oe_o));

  // R3
  ale_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_no |=> (ale_no && !den_no));

  // R4
  ads_first_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_no |=> ads_no);

  // R4
  ads_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!den_no && !ready_i) |=> ads_no);

  // R5
  dir_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !den_no |=> ($stable(dtr_o) && $stable(wr_o)));

  // R5
  dir_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_no |-> (dtr_o == wr_o));

  // R2
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(!den_no && !dtr_o && ready_i));

  // R8
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_no && wr_o) |-> !lock_oe_o);

  // R10
  bus_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_no && den_no) |-> !bus_ad_oe_o);

  // R10
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !den_no |-> !req_ready_o);

  // R11
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ale_no && den_no));
endmodule

bind lbus_master lbus_master_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .err_o       (err_o),
  .rvalid_o    (rvalid_o),
  .bus_ad_oe_o (bus_ad_oe_o),
  .ale_no      (ale_no),
  .ads_no      (ads_no),
  .wr_o        (wr_o),
  .dtr_o       (dtr_o),
  .den_no      (den_no),
  .ready_i     (ready_i),
  .lock_oe_o   (lock_oe_o)
);

// File: tb/lbus_master_bench.sv
module lbus_master_bench;
  localparam int DW = 32;
  localparam int MB = 4;
  localparam int WA_W = 30;
  localparam int NV = 12;

  // {op[1:0], len[2:0], waits[1:0], err, addr[29:0]}
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 3'd1, 2'd0, 1'b0, 30'h0000_0100},
    {2'd0, 3'd4, 2'd0, 1'b0, 30'h0000_0104},
    {2'd1, 3'd3, 2'd1, 1'b0, 30'h0000_0201},
    {2'd0, 3'd2, 2'd2, 1'b0, 30'h0000_0302},
    {2'd1, 3'd4, 2'd0, 1'b0, 30'h0000_0400},
    {2'd3, 3'd1, 2'd1, 1'b0, 30'h0000_0000},
    {2'd2, 3'd1, 2'd0, 1'b0, 30'h0000_0503},
    {2'd2, 3'd2, 2'd1, 1'b0, 30'h0000_0508},
    {2'd0, 3'd4, 2'd0, 1'b1, 30'h0000_0601},
    {2'd1, 3'd0, 2'd0, 1'b1, 30'h0000_0700},
    {2'd0, 3'd5, 2'd0, 1'b1, 30'h0000_0710},
    {2'd1, 3'd1, 2'd2, 1'b0, 30'h3FFF_FFFF}
  };

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [1:0]        req_op_i = '0;
  logic [WA_W-1:0]   req_addr_i = '0;
  logic [2:0]        req_len_i = '0;
  logic [MB*DW-1:0]  req_wdata_i = '0;
  logic              err_o, rvalid_o;
  logic [DW-1:0]     rdata_o;
  logic [DW-1:0]     bus_ad_i = '0;
  logic [DW-1:0]     bus_ad_o;
  logic              bus_ad_oe_o, ale_no, ads_no, wr_o, dtr_o, den_no;
  logic              ready_i = 1'b0;
  logic              lock_i = 1'b0;
  logic              lock_oe_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lbus_master u_lbus_master (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_op_i(req_op_i), .req_addr_i(req_addr_i), .req_len_i(req_len_i),
    .req_wdata_i(req_wdata_i), .err_o(err_o), .rdata_o(rdata_o), .rvalid_o(rvalid_o),
    .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o), .bus_ad_oe_o(bus_ad_oe_o),
    .ale_no(ale_no), .ads_no(ads_no), .wr_o(wr_o), .dtr_o(dtr_o), .den_no(den_no),
    .ready_i(ready_i), .lock_i(lock_i), .lock_oe_o(lock_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [29:0] a);
    return {a, 2'b00} ^ 32'h5A00_00C3;
  endfunction

  function automatic logic [31:0] wd_word(input logic [29:0] a, input int b);
    return ({a, 2'b00} + 32'(b) * 32'h1111_1111) ^ 32'hC3C3_0000;
  endfunction

  task automatic run_txn(input logic [1:0] op, input logic [29:0] a, input logic [2:0] len,
                         input int waits, input bit exp_err, input int lock_cyc);
    int  phases, phase, beat, wcnt;
    bit  prev_acc, pend, end_flag, done, is_wr, exp_lock;
    logic [31:0] pend_val, exp_ad;
    @(negedge clk);
    req_op_i = op; req_addr_i = a; req_len_i = len; req_valid_i = 1'b1;
    for (int b = 0; b < MB; b++) req_wdata_i[b*DW +: DW] = wd_word(a, b);
    if (lock_cyc > 0) lock_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    if (exp_err) begin
      chk(err_o == 1'b1, "R11 err pulse", 32'(err_o), 32'd1);
      chk(ale_no && den_no && !bus_ad_oe_o, "R11 no bus", {ale_no, den_no, bus_ad_oe_o}, 32'h6);
      @(negedge clk);
      chk(err_o == 1'b0 && ale_no, "R11 single pulse", {err_o, ale_no}, 32'h1);
      return;
    end
    chk(err_o == 1'b0, "R11 accepted", 32'(err_o), 32'd0);
    for (int k = 0; k < lock_cyc; k++) begin
      chk(ale_no && !lock_oe_o, "R8 lock wait", {ale_no, lock_oe_o}, 32'h2);
      if (k == lock_cyc - 1) lock_i = 1'b0;
      @(negedge clk);
    end
    phases = (op == 2'd2) ? 2 : 1;
    phase = 0; beat = 0; wcnt = 0;
    prev_acc = 0; pend = 0; end_flag = 0; done = 0; is_wr = 0;
    pend_val = '0;
    for (int cyc = 0; cyc < 200 && !done; cyc++) begin
      ready_i = 1'b0;
      bus_ad_i = 32'hDEAD_BEEF;
      if (pend) chk(rvalid_o && rdata_o == pend_val, "R2 read word", rdata_o, pend_val);
      else chk(!rvalid_o, "R2 no stray valid", 32'(rvalid_o), 32'd0);
      pend = 0;
      exp_lock = (op == 2'd3) || (op == 2'd2 && phase == 0);
      if (!ale_no) begin
        is_wr = (op == 2'd1) || (op == 2'd2 && phase == 1);
        exp_ad = {a, 2'(len - 3'd1)};
        chk(bus_ad_o == exp_ad, "R1 address word", bus_ad_o, exp_ad);
        chk(bus_ad_oe_o && !ads_no && den_no, "R1 strobes", {bus_ad_oe_o, ads_no, den_no}, 32'h5);
        chk(wr_o == is_wr && dtr_o == is_wr, "R5 direction", {wr_o, dtr_o}, {is_wr, is_wr});
        chk(lock_oe_o == exp_lock, (op == 2'd3) ? "R9 lock addr" : "R8 lock addr",
            32'(lock_oe_o), 32'(exp_lock));
        chk(!req_ready_o, "R10 busy", 32'(req_ready_o), 32'd0);
        beat = 0; wcnt = 0; prev_acc = 0;
      end else if (!den_no) begin
        chk(ads_no == !prev_acc, "R4 ads", 32'(ads_no), 32'(!prev_acc));
        chk(ale_no, "R3 ale high in data", 32'(ale_no), 32'd1);
        chk(wr_o == is_wr && dtr_o == is_wr, "R5 held", {wr_o, dtr_o}, {is_wr, is_wr});
        chk(lock_oe_o == exp_lock, (op == 2'd3) ? "R9 lock data" : "R8 lock data",
            32'(lock_oe_o), 32'(exp_lock));
        if (is_wr) begin
          chk(bus_ad_oe_o && bus_ad_o == wd_word(a, beat), (wcnt > 0) ? "R7 wait data" : "R2 write data",
              bus_ad_o, wd_word(a, beat));
        end else begin
          chk(!bus_ad_oe_o, "R2 read released", 32'(bus_ad_oe_o), 32'd0);
          bus_ad_i = mem_word(a + 30'(beat));
        end
        if (wcnt < waits) begin
          wcnt++; prev_acc = 0;
        end else begin
          ready_i = 1'b1; wcnt = 0; prev_acc = 1;
          if (!is_wr) begin pend = 1; pend_val = mem_word(a + 30'(beat)); end
          beat++;
          if (beat == int'(len)) begin phase++; end_flag = 1; end
        end
      end else begin
        chk(den_no && ads_no, "R6 idle strobes", {den_no, ads_no}, 32'h3);
        if (end_flag) begin
          chk(!bus_ad_oe_o, "R10 released", 32'(bus_ad_oe_o), 32'd0);
          if (phase == phases) begin
            chk(req_ready_o, "R10 ready again", 32'(req_ready_o), 32'd1);
            done = 1;
          end else begin
            chk(!req_ready_o && lock_oe_o, "R8 gap holds lock", {req_ready_o, lock_oe_o}, 32'h1);
          end
          end_flag = 0;
        end
      end
      if (!done) @(negedge clk);
    end
    ready_i = 1'b0;
    chk(done, "R10 completion", 32'(done), 32'd1);
    if (done) begin
      @(negedge clk);
      chk(!rvalid_o, "R2 no extra valid", 32'(rvalid_o), 32'd0);
    end
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(ale_no && ads_no && den_no && !bus_ad_oe_o && !lock_oe_o && !rvalid_o && !err_o && req_ready_o,
        "R12 reset idle",
        {ale_no, ads_no, den_no, bus_ad_oe_o, lock_oe_o, rvalid_o, err_o, req_ready_o}, 32'hE1);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      run_txn(VEC[i][37:36], VEC[i][29:0], VEC[i][35:33], int'(VEC[i][32:31]), VEC[i][30], 0);
    end

    // R8 lock held by another agent for three cycles
    run_txn(2'd2, 30'h0000_0900, 3'd2, 0, 1'b0, 3);

    // R12 reset in the middle of a burst
    @(negedge clk);
    req_op_i = 2'd0; req_addr_i = 30'h0000_0A00; req_len_i = 3'd4; req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    @(negedge clk);
    chk(!den_no, "R6 data state before reset", 32'(den_no), 32'd0);
    rst_ni = 1'b0;
    #1;
    chk(ale_no && ads_no && den_no && !bus_ad_oe_o && !lock_oe_o && req_ready_o,
        "R12 async reset",
        {ale_no, ads_no, den_no, bus_ad_oe_o, lock_oe_o, req_ready_o}, 32'h39);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ale_no && den_no && !rvalid_o, "R12 stays idle", {ale_no, den_no, rvalid_o}, 32'h6);

    // back-to-back after reset
    run_txn(2'd1, 30'h0000_0B02, 3'd2, 1, 1'b0, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule